// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits beside the page-load logic of a byte-wide flash array. It sees each byte-load cycle as a one-cycle strobe that carries an address and a data byte. It looks for multi-byte command patterns in that stream. These patterns turn software write protection on or off, and move the device into or out of identification mode.

For every load it drives a combinational `permit` bit. This bit tells the page controller whether the byte may enter the page buffer as data. When protection is on, a data load without the short unlock prefix starts a timed lockout. During the lockout every load is ignored.

Three-load patterns and six-load patterns begin with the same two steps. The decoder therefore tracks one shared step counter. It branches on the third byte.

Top module: `unlock_seq_decoder`

## Requirements
- R1: After reset, `protect_on`, `id_mode` and `locked` are 0, and a data load is permitted.
- R2: Only address bits 14..0 take part in command matching, so bits above 14 may have any value.
- R3: The loads 5555h/AAh, 2AAAh/55h, 5555h/A0h, on consecutive strobes, set `protect_on` to 1 and open a data window.
- R4: The six loads 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, 5555h/20h clear `protect_on`.
- R5: The same first five loads followed by 5555h/60h set `id_mode`. The loads 5555h/AAh, 2AAAh/55h, 5555h/F0h clear it. Neither sequence changes `protect_on`.
- R6: While `protect_on` is 1, a data load is permitted only inside the window opened by R3. The window stays open while each load follows the previous one within WINDOW cycles, and closes after a longer gap.
- R7: A non-command load while `protect_on` is 1 and no window is open is not permitted. It raises `locked` for LOCK_CYCLES cycles, and during that time every load is ignored and no flag changes.
- R8: A load that does not match the expected next step sends the decoder back to idle. The same load is then tried as the first step of a new sequence.
- R9: A load that the decoder consumes as a command step is never permitted as data.
- R10: While the data window is open, every load is treated as data and none is decoded as a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | One-cycle strobe per byte-load cycle |
| load_addr | input | ADDR_W | Byte-load address |
| load_data | input | 8 | Byte-load data |
| permit | output | 1 | Current load may enter the page buffer |
| protect_on | output | 1 | Software write protection active |
| id_mode | output | 1 | Identification mode active |
| locked | output | 1 | Lockout after a blocked write is running |

## Verification
A single load can end a partly entered sequence and also be a blocked write while protection is on. In that one cycle the step counter must drop to idle and the lockout must start. The bench provokes this with AAh, 55h, then a stray 33h at 5555h under protection. It expects `permit` low and `locked` high on the next cycle. Once the lockout expires it sends 5555h/A0h. If the step counter had stayed at step 2, this load would complete a set-protect command. Because the counter returned to idle, the bench must instead see a second blocked write.

// File: rtl/unlock_seq_decoder.sv
module unlock_seq_decoder #(
  parameter int ADDR_W      = 17,
  parameter int LOCK_CYCLES = 25000,
  parameter int WINDOW      = 12500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_valid,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [7:0]        load_data,
  output logic              permit,
  output logic              protect_on,
  output logic              id_mode,
  output logic              locked
);
  localparam int LCW = $clog2(LOCK_CYCLES + 1);
  localparam int WCW = $clog2(WINDOW + 1);

  logic [2:0]     step;
  logic           armed;
  logic [LCW-1:0] lock_cnt;
  logic [WCW-1:0] win_cnt;

  wire a_hi = load_addr[14:0] == 15'h5555;
  wire a_lo = load_addr[14:0] == 15'h2AAA;

  function automatic logic hit_at(input logic [2:0] s);
    case (s)
      3'd0, 3'd3: hit_at = a_hi && load_data == 8'hAA;
      3'd1, 3'd4: hit_at = a_lo && load_data == 8'h55;
      3'd2:       hit_at = a_hi && (load_data == 8'hA0 || load_data == 8'hF0 || load_data == 8'h80);
      3'd5:       hit_at = a_hi && (load_data == 8'h20 || load_data == 8'h60);
      default:    hit_at = 1'b0;
    endcase
  endfunction

  wire       active   = load_valid && !locked;
  wire       on_path  = hit_at(step);
  wire       restart  = hit_at(3'd0);
  wire       cmd_hit  = !armed && (on_path || restart);
  wire [2:0] cur      = on_path ? step : 3'd0;
  wire       blocked  = active && !armed && !cmd_hit && protect_on;

  assign locked = lock_cnt != '0;
  assign permit = active && (armed || (!cmd_hit && !protect_on));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step       <= 3'd0;
      armed      <= 1'b0;
      protect_on <= 1'b0;
      id_mode    <= 1'b0;
      lock_cnt   <= '0;
      win_cnt    <= '0;
    end else begin
      if (locked) lock_cnt <= lock_cnt - 1'b1;
      if (armed && !active) begin
        if (win_cnt == WCW'(WINDOW - 1)) armed <= 1'b0;
        else win_cnt <= win_cnt + 1'b1;
      end
      if (active) begin
        if (armed) begin
          win_cnt <= '0;
          step    <= 3'd0;
        end else if (cmd_hit) begin
          case (cur)
            3'd2: begin
              step <= (load_data == 8'h80) ? 3'd3 : 3'd0;
              if (load_data == 8'hA0) begin
                protect_on <= 1'b1;
                armed      <= 1'b1;
                win_cnt    <= '0;
              end
              if (load_data == 8'hF0) id_mode <= 1'b0;
            end
            3'd5: begin
              step <= 3'd0;
              if (load_data == 8'h20) protect_on <= 1'b0;
              if (load_data == 8'h60) id_mode    <= 1'b1;
            end
            default: step <= cur + 3'd1;
          endcase
        end else begin
          step <= 3'd0;
          if (blocked) lock_cnt <= LCW'(LOCK_CYCLES);
        end
      end
    end
  end

  p_set_prot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !armed && step == 3'd2 && a_hi && load_data == 8'hA0) |=> (protect_on && armed));
  p_clear_prot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !armed && step == 3'd5 && a_hi && load_data == 8'h20) |=> !protect_on);
  p_id_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !armed && step == 3'd5 && a_hi && load_data == 8'h60) |=> (id_mode && $stable(protect_on)));
  p_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (permit && protect_on) |-> armed);
  p_lock_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(load_valid && protect_on && !armed));
  p_lock_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(protect_on) && $stable(id_mode)));
  p_step_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step <= 3'd5);
endmodule

// File: tb/unlock_seq_decoder_tb.sv
module unlock_seq_decoder_tb;
  localparam int ADDR_W = 17;
  localparam int LOCK   = 40;
  localparam int WIN    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_valid = 1'b0;
  logic [ADDR_W-1:0] load_addr = '0;
  logic [7:0] load_data = '0;
  logic permit, protect_on, id_mode, locked;

  int checks = 0;
  int fails = 0;
  bit exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  unlock_seq_decoder #(.ADDR_W(ADDR_W), .LOCK_CYCLES(LOCK), .WINDOW(WIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_addr(load_addr),
    .load_data(load_data), .permit(permit), .protect_on(protect_on),
    .id_mode(id_mode), .locked(locked));

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic ld(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                    input bit exp, input string tag, input int idle = 1);
    @(negedge clk);
    load_valid = 1'b1; load_addr = a; load_data = d;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    load_valid = 1'b0;
    repeat (idle) @(negedge clk);
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (load_valid) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL scoreboard unexpected load actual=1 expected=0");
        end else begin
          bit e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(permit, e, t);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    gap(3);
    rst_n = 1'b1;
    gap(1);
    chk(protect_on, 1'b0, "R1 protect after reset");
    chk(id_mode, 1'b0, "R1 id after reset");
    chk(locked, 1'b0, "R1 locked after reset");
    ld(17'h00100, 8'h12, 1'b1, "R1 data load unprotected");

    // R2, R3, R9: set protection with A16 high
    ld(17'h15555, 8'hAA, 1'b0, "R9 cmd step1");
    ld(17'h12AAA, 8'h55, 1'b0, "R9 cmd step2");
    ld(17'h15555, 8'hA0, 1'b0, "R2 cmd step3 upper bits ignored");
    chk(protect_on, 1'b1, "R3 protect set");
    ld(17'h00200, 8'h34, 1'b1, "R6 data in window", 2);
    ld(17'h00201, 8'h35, 1'b1, "R6 data in window second", 2);

    // R6, R7: window expires, blocked write
    gap(WIN + 20);
    ld(17'h00202, 8'h36, 1'b0, "R6 data after window");
    chk(locked, 1'b1, "R7 lockout started");
    ld(17'h05555, 8'hAA, 1'b0, "R7 ignored while locked");
    ld(17'h02AAA, 8'h55, 1'b0, "R7 ignored while locked");
    chk(protect_on, 1'b1, "R7 protect frozen");
    gap(LOCK + 5);
    chk(locked, 1'b0, "R7 lockout ends");
    ld(17'h05555, 8'hA0, 1'b0, "R7 loads during lock not decoded");
    chk(locked, 1'b1, "R7 re-blocked");
    gap(LOCK + 5);

    // R8: repeated first step restarts
    ld(17'h05555, 8'hAA, 1'b0, "R8 first AA");
    ld(17'h05555, 8'hAA, 1'b0, "R8 repeated AA restarts");
    ld(17'h02AAA, 8'h55, 1'b0, "R8 55");
    ld(17'h05555, 8'hA0, 1'b0, "R8 A0");
    chk(locked, 1'b0, "R8 no lockout on restart");
    ld(17'h00300, 8'h77, 1'b1, "R8 data after restarted prefix");

    // R10: command pattern inside window is data
    ld(17'h05555, 8'hAA, 1'b1, "R10 AA in window is data");
    ld(17'h02AAA, 8'h55, 1'b1, "R10 55 in window is data");
    gap(WIN + 20);

    // abort plus blocked write in one cycle
    ld(17'h05555, 8'hAA, 1'b0, "R8 partial AA");
    ld(17'h02AAA, 8'h55, 1'b0, "R8 partial 55");
    ld(17'h05555, 8'h33, 1'b0, "R7 stray byte blocked");
    chk(locked, 1'b1, "R7 lockout on stray");
    gap(LOCK + 5);
    ld(17'h05555, 8'hA0, 1'b0, "R8 step reset by stray");
    chk(locked, 1'b1, "R8 A0 alone blocked");
    gap(LOCK + 5);

    // R4: clear protection
    ld(17'h05555, 8'hAA, 1'b0, "R4 s1");
    ld(17'h02AAA, 8'h55, 1'b0, "R4 s2");
    ld(17'h05555, 8'h80, 1'b0, "R4 s3");
    ld(17'h05555, 8'hAA, 1'b0, "R4 s4");
    ld(17'h02AAA, 8'h55, 1'b0, "R4 s5");
    ld(17'h05555, 8'h20, 1'b0, "R4 s6");
    chk(protect_on, 1'b0, "R4 protect cleared");
    ld(17'h00400, 8'h99, 1'b1, "R4 data after clear");

    // R5: ID entry and exit
    ld(17'h05555, 8'hAA, 1'b0, "R5 e1");
    ld(17'h02AAA, 8'h55, 1'b0, "R5 e2");
    ld(17'h05555, 8'h80, 1'b0, "R5 e3");
    ld(17'h05555, 8'hAA, 1'b0, "R5 e4");
    ld(17'h02AAA, 8'h55, 1'b0, "R5 e5");
    ld(17'h05555, 8'h60, 1'b0, "R5 e6");
    chk(id_mode, 1'b1, "R5 id entered");
    chk(protect_on, 1'b0, "R5 protect untouched");
    ld(17'h05555, 8'hAA, 1'b0, "R5 x1");
    ld(17'h02AAA, 8'h55, 1'b0, "R5 x2");
    ld(17'h05555, 8'hF0, 1'b0, "R5 x3");
    chk(id_mode, 1'b0, "R5 id exited");

    // R8: wrong last byte of six-load sequence is data
    ld(17'h05555, 8'hAA, 1'b0, "R8 a1");
    ld(17'h02AAA, 8'h55, 1'b0, "R8 a2");
    ld(17'h05555, 8'h80, 1'b0, "R8 a3");
    ld(17'h05555, 8'hAA, 1'b0, "R8 a4");
    ld(17'h02AAA, 8'h55, 1'b0, "R8 a5");
    ld(17'h05555, 8'hA0, 1'b1, "R8 mismatch at step6 is data");
    chk(protect_on, 1'b0, "R8 protect unchanged");

    gap(4);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard pending actual=%0d expected=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule